// File: doc/BRIEF.md
# Panel Power-Up Command Sequencer

This block takes a display panel from its reset state to a running, visible picture without software stepping through the bring-up. It drives the panel reset line and the supply enable. It plays a fixed script that mixes register writes with waits of two kinds. A millisecond wait is timed from the system clock. A frame wait counts rising edges of the vertical sync pulse that the timing generator produces. The timing generator must therefore already be running while the script plays.

Register writes leave the block as address/data requests on a simple request/acknowledge handshake to a separate write master, which owns the serial link. Once the panel is on, the block follows a display-enable input. When that input drops, it plays a standby-entry script. When the input returns, it plays a standby-exit script, which wakes the panel and repeats the power and display-on writes. The script lives in an internal table whose entries are writes, millisecond waits, frame waits, line controls, jumps and end markers.

Top module: `panel_bringup_seq`

## Requirements
- R1: While rstN is low, wrReq, panelRst, pwrEn and displayOn are all 0.
- R2: After reset the reset line goes high, then low, then high again. The first two levels each last exactly 10*CLKS_PER_MS+2 cycles.
- R3: pwrEn rises 10*CLKS_PER_MS+2 cycles after the final rise of panelRst. The first write request rises 10*CLKS_PER_MS+2 cycles after pwrEn. While pwrEn is high, panelRst stays high, and pwrEn never falls again.
- R4: The boot script writes, in this order (address=data, hex): 07=0000, 12=1618, 11=2227, 13=61D1, 10=550C, 12=0C58, 07=0001, 07=0101, 76=2213, 1C=6650, 0B=33E1, 76=0000, 07=0103.
- R5: wrReq stays high, with wrAddr and wrData unchanged, until wrAck is high in the same cycle. Each such cycle moves exactly one write, and any acknowledge latency is accepted.
- R6: A 10 ms wait follows the write 07=0000 of the power part. The next request rises 10*CLKS_PER_MS+2 cycles after that write is accepted.
- R7: A frame wait of N counts vsync rising edges (vsync high in a cycle, low in the cycle before), starting two cycles after the preceding write is accepted. The next request rises in the cycle after the (N+1)th counted edge. The waits are: 5 after 10=550C, 1 after 07=0001, 2 after 07=0101, and 2 after 07=0102.
- R8: displayOn rises two cycles after the last write of the boot or wake script is accepted. It falls two cycles after the last write of the standby-entry script is accepted. It never changes in a cycle in which wrReq is high.
- R9: Standby entry writes 0B=30E1, 07=0102, 07=0000, 12=0000, 10=0100, 10=0001, in that order.
- R10: Standby exit writes 10=0000 and then the same 13 writes as R4, in the same order and with the same waits.
- R11: When panelEnable already equals displayOn while the block is idle, no write is issued and displayOn holds.
- R12: panelEnable is examined only while idle. If panelEnable is low when boot finishes, the first standby-entry request rises one cycle after displayOn rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| panelEnable | input | 1 | Requested display state (1 = on) |
| vsync | input | 1 | Vertical sync from the timing generator |
| wrAck | input | 1 | Write master has taken the current request |
| wrReq | output | 1 | Register write request |
| wrAddr | output | 8 | Panel register address |
| wrData | output | 16 | Panel register value |
| panelRst | output | 1 | Level of the panel reset line |
| pwrEn | output | 1 | Panel supply enable |
| displayOn | output | 1 | Current display state |

## Verification
The bench builds the block with CLKS_PER_MS=3, TMR_W=8 and FRM_W=3, so each 10 ms wait lasts 30 clocks. This makes the exact reset-level and power-up spacings measurable within a few hundred cycles. vsync runs with a 40-cycle period, which puts the five-frame wait and every shorter frame wait inside one short run. The acknowledge latency rotates through 0, 1 and 2 cycles, so that the handshake is exercised both with and without back-pressure.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int PC_W   = 6;

  // entry points into the script table
  localparam logic [PC_W-1:0] WAKE_PC  = PC_W'(0);
  localparam logic [PC_W-1:0] BOOT_PC  = PC_W'(19);
  localparam logic [PC_W-1:0] SLEEP_PC = PC_W'(28);

  typedef enum logic [2:0] {OP_WR, OP_MS, OP_FR, OP_RST, OP_PWR, OP_JMP, OP_END} op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] arg;
  } entry_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              loadMs;
    logic              loadFr;
    logic              setRst;
    logic              setPwr;
    logic              setOn;
    logic [DATA_W-1:0] arg;
  } strobe_t;

  function automatic entry_t mkEnt(op_e op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    entry_t e;
    e.op = op;
    e.addr = a;
    e.arg = d;
    return e;
  endfunction

  // wake (0..18): leave standby, power part, display-on part, end(on)
  // boot (19..27): line control with 10 ms holds, then jump into the power part
  // sleep (28..35): display off, deep standby, end(off)
  function automatic entry_t scriptAt(logic [PC_W-1:0] pc);
    case (pc)
      6'd0:  return mkEnt(OP_WR,  8'h10, 16'h0000);
      6'd1:  return mkEnt(OP_WR,  8'h07, 16'h0000);
      6'd2:  return mkEnt(OP_MS,  8'h00, 16'd10);
      6'd3:  return mkEnt(OP_WR,  8'h12, 16'h1618);
      6'd4:  return mkEnt(OP_WR,  8'h11, 16'h2227);
      6'd5:  return mkEnt(OP_WR,  8'h13, 16'h61D1);
      6'd6:  return mkEnt(OP_WR,  8'h10, 16'h550C);
      6'd7:  return mkEnt(OP_FR,  8'h00, 16'd5);
      6'd8:  return mkEnt(OP_WR,  8'h12, 16'h0C58);
      6'd9:  return mkEnt(OP_WR,  8'h07, 16'h0001);
      6'd10: return mkEnt(OP_FR,  8'h00, 16'd1);
      6'd11: return mkEnt(OP_WR,  8'h07, 16'h0101);
      6'd12: return mkEnt(OP_FR,  8'h00, 16'd2);
      6'd13: return mkEnt(OP_WR,  8'h76, 16'h2213);
      6'd14: return mkEnt(OP_WR,  8'h1C, 16'h6650);
      6'd15: return mkEnt(OP_WR,  8'h0B, 16'h33E1);
      6'd16: return mkEnt(OP_WR,  8'h76, 16'h0000);
      6'd17: return mkEnt(OP_WR,  8'h07, 16'h0103);
      6'd18: return mkEnt(OP_END, 8'h00, 16'h0001);
      6'd19: return mkEnt(OP_RST, 8'h00, 16'h0001);
      6'd20: return mkEnt(OP_MS,  8'h00, 16'd10);
      6'd21: return mkEnt(OP_RST, 8'h00, 16'h0000);
      6'd22: return mkEnt(OP_MS,  8'h00, 16'd10);
      6'd23: return mkEnt(OP_RST, 8'h00, 16'h0001);
      6'd24: return mkEnt(OP_MS,  8'h00, 16'd10);
      6'd25: return mkEnt(OP_PWR, 8'h00, 16'h0001);
      6'd26: return mkEnt(OP_MS,  8'h00, 16'd10);
      6'd27: return mkEnt(OP_JMP, 8'h00, 16'd1);
      6'd28: return mkEnt(OP_WR,  8'h0B, 16'h30E1);
      6'd29: return mkEnt(OP_WR,  8'h07, 16'h0102);
      6'd30: return mkEnt(OP_FR,  8'h00, 16'd2);
      6'd31: return mkEnt(OP_WR,  8'h07, 16'h0000);
      6'd32: return mkEnt(OP_WR,  8'h12, 16'h0000);
      6'd33: return mkEnt(OP_WR,  8'h10, 16'h0100);
      6'd34: return mkEnt(OP_WR,  8'h10, 16'h0001);
      6'd35: return mkEnt(OP_END, 8'h00, 16'h0000);
      default: return mkEnt(OP_END, 8'h00, 16'h0000);
    endcase
  endfunction
endpackage

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              panelEnable,
  input  logic              displayOn,
  input  logic              msDone,
  input  logic              frDone,
  input  logic              wrAck,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output strobe_t           strobe
);
  typedef enum logic [1:0] {S_RUN, S_WMS, S_WFR, S_IDLE} state_e;

  state_e          state, stateNext;
  logic [PC_W-1:0] pc, pcNext;
  entry_t          cur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_RUN;
      pc    <= BOOT_PC;
    end else begin
      state <= stateNext;
      pc    <= pcNext;
    end
  end

  always_comb begin
    cur       = scriptAt(pc);
    stateNext = state;
    pcNext    = pc;
    strobe    = '0;
    strobe.arg = cur.arg;
    wrReq     = 1'b0;
    wrAddr    = cur.addr;
    wrData    = cur.arg;
    case (state)
      S_RUN: begin
        case (cur.op)
          OP_WR: begin
            wrReq = 1'b1;
            if (wrAck) pcNext = pc + 1'b1;
          end
          OP_MS: begin
            strobe.loadMs = 1'b1;
            stateNext = S_WMS;
          end
          OP_FR: begin
            strobe.loadFr = 1'b1;
            stateNext = S_WFR;
          end
          OP_RST: begin
            strobe.setRst = 1'b1;
            pcNext = pc + 1'b1;
          end
          OP_PWR: begin
            strobe.setPwr = 1'b1;
            pcNext = pc + 1'b1;
          end
          OP_JMP: pcNext = cur.arg[PC_W-1:0];
          OP_END: begin
            strobe.setOn = 1'b1;
            stateNext = S_IDLE;
          end
          default: ;
        endcase
      end
      S_WMS: if (msDone) begin
        pcNext = pc + 1'b1;
        stateNext = S_RUN;
      end
      S_WFR: if (frDone) begin
        pcNext = pc + 1'b1;
        stateNext = S_RUN;
      end
      S_IDLE: if (panelEnable != displayOn) begin
        pcNext = displayOn ? SLEEP_PC : WAKE_PC;
        stateNext = S_RUN;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pseq_dpath.sv
module pseq_dpath
  import pseq_pkg::*;
#(
  parameter int CLKS_PER_MS = 24000,
  parameter int TMR_W       = 24,
  parameter int FRM_W       = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    vsync,
  input  strobe_t strobe,
  output logic    panelRst,
  output logic    pwrEn,
  output logic    displayOn,
  output logic    msDone,
  output logic    frDone
);
  localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);
  localparam logic [FRM_W-1:0] FRM_ONE = FRM_W'(1);

  logic [TMR_W-1:0] msCnt;
  logic [FRM_W-1:0] frCnt;
  logic             vsPrev;
  logic             vsEdge;

  assign vsEdge = vsync & ~vsPrev;
  assign msDone = (msCnt == TMR_ONE);
  assign frDone = vsEdge && (frCnt == FRM_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt     <= '0;
      frCnt     <= '0;
      vsPrev    <= 1'b0;
      panelRst  <= 1'b0;
      pwrEn     <= 1'b0;
      displayOn <= 1'b0;
    end else begin
      vsPrev <= vsync;
      if (strobe.loadMs)
        msCnt <= TMR_W'(32'(strobe.arg) * 32'(CLKS_PER_MS));
      else if (msCnt != '0)
        msCnt <= msCnt - 1'b1;
      // one extra edge so that N whole frames pass
      if (strobe.loadFr)
        frCnt <= FRM_W'(strobe.arg) + FRM_ONE;
      else if (vsEdge && frCnt != '0)
        frCnt <= frCnt - 1'b1;
      if (strobe.setRst) panelRst  <= strobe.arg[0];
      if (strobe.setPwr) pwrEn     <= strobe.arg[0];
      if (strobe.setOn)  displayOn <= strobe.arg[0];
    end
  end
endmodule

// File: rtl/panel_bringup_seq.sv
module panel_bringup_seq
  import pseq_pkg::*;
#(
  parameter int CLKS_PER_MS = 24000,
  parameter int TMR_W       = 24,
  parameter int FRM_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              panelEnable,
  input  logic              vsync,
  input  logic              wrAck,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              panelRst,
  output logic              pwrEn,
  output logic              displayOn
);
  strobe_t strobe;
  logic    msDone;
  logic    frDone;

  pseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .panelEnable(panelEnable), .displayOn(displayOn),
    .msDone(msDone), .frDone(frDone), .wrAck(wrAck),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe)
  );

  pseq_dpath #(.CLKS_PER_MS(CLKS_PER_MS), .TMR_W(TMR_W), .FRM_W(FRM_W)) u_dpath (
    .clk(clk), .rstN(rstN), .vsync(vsync), .strobe(strobe),
    .panelRst(panelRst), .pwrEn(pwrEn), .displayOn(displayOn),
    .msDone(msDone), .frDone(frDone)
  );
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk
  import pseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrReq,
  input logic              wrAck,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              panelRst,
  input logic              pwrEn,
  input logic              displayOn
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> (wrReq && $stable(wrAddr) && $stable(wrData)));

  assert_pwr_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(pwrEn));

  assert_rst_under_pwr_R3: assert property (@(posedge clk) disable iff (!rstN)
    pwrEn |-> panelRst);

  assert_rst_static_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(panelRst) || $fell(panelRst)) |-> !pwrEn);

  assert_on_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(displayOn) || $fell(displayOn)) |-> !wrReq);
endmodule

bind panel_bringup_seq pseq_chk u_chk (
  .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAck(wrAck), .wrAddr(wrAddr),
  .wrData(wrData), .panelRst(panelRst), .pwrEn(pwrEn), .displayOn(displayOn)
);

// File: tb/sim_panel_bringup_seq.sv
module sim_panel_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPM  = 3;
  localparam int MSW  = 10 * CPM + 2;
  localparam int VPER = 40;

  logic clk = 1'b0, rstN = 1'b0, panelEnable = 1'b0, vsync = 1'b0, wrAck = 1'b0;
  logic wrReq, panelRst, pwrEn, displayOn;
  logic [7:0]  wrAddr;
  logic [15:0] wrData;

  int checks = 0, errors = 0;
  bit done = 0;

  int logA[0:63], logD[0:63], logAck[0:63], logReq[0:63], logFrExp[0:63];
  int nLog = 0, cyc = 0;
  int reqRise = 0, waitCnt = 0;
  bit reqPrev = 0, prevAcc = 0, vsPrevTb = 0;
  bit frArmed = 0;
  int frStart = 0, frNeed = 0, frSeen = 0, pendExp = -1;
  int rstEdge[0:7];
  int nRstEdge = 0, pwrRise = -1, pwrFalls = 0, onRise = -1, onFall = -1;
  bit rstLast = 0, pwrLast = 0, onLast = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_bringup_seq #(.CLKS_PER_MS(CPM), .TMR_W(8), .FRM_W(3)) u0 (
    .clk(clk), .rstN(rstN), .panelEnable(panelEnable), .vsync(vsync), .wrAck(wrAck),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .panelRst(panelRst), .pwrEn(pwrEn), .displayOn(displayOn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wake list: 10=0000 followed by the 13 writes of R4
  function automatic logic [23:0] expWake(int i);
    case (i)
      0: return 24'h10_0000;   1: return 24'h07_0000;   2: return 24'h12_1618;
      3: return 24'h11_2227;   4: return 24'h13_61D1;   5: return 24'h10_550C;
      6: return 24'h12_0C58;   7: return 24'h07_0001;   8: return 24'h07_0101;
      9: return 24'h76_2213;  10: return 24'h1C_6650;  11: return 24'h0B_33E1;
      12: return 24'h76_0000; 13: return 24'h07_0103;
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic [23:0] expSleep(int i);
    case (i)
      0: return 24'h0B_30E1; 1: return 24'h07_0102; 2: return 24'h07_0000;
      3: return 24'h12_0000; 4: return 24'h10_0100; 5: return 24'h10_0001;
      default: return 24'h0;
    endcase
  endfunction

  function automatic int framesAfter(int a, int d);
    if (a == 'h10 && d == 'h550C) return 5;
    if (a == 'h07 && d == 'h0001) return 1;
    if (a == 'h07 && d == 'h0101) return 2;
    if (a == 'h07 && d == 'h0102) return 2;
    return 0;
  endfunction

  // monitor and responder: samples at the falling edge, drives for the next rising edge
  always @(negedge clk) begin
    cyc++;
    vsync = ((cyc % VPER) < 4);
    if (vsync && !vsPrevTb && frArmed && cyc >= frStart) begin
      frSeen++;
      if (frSeen == frNeed + 1) begin
        pendExp = cyc + 1;
        frArmed = 0;
      end
    end
    vsPrevTb = vsync;
    if (wrReq && (!reqPrev || prevAcc)) reqRise = cyc;
    if (wrReq) begin
      if (waitCnt >= (nLog % 3)) wrAck = 1'b1;
      else begin wrAck = 1'b0; waitCnt++; end
    end else begin
      wrAck = 1'b0;
      waitCnt = 0;
    end
    prevAcc = wrReq && wrAck;
    reqPrev = wrReq;
    if (prevAcc && nLog < 64) begin
      logA[nLog] = int'(wrAddr);
      logD[nLog] = int'(wrData);
      logAck[nLog] = cyc;
      logReq[nLog] = reqRise;
      logFrExp[nLog] = pendExp;
      pendExp = -1;
      frArmed = 0;
      if (framesAfter(int'(wrAddr), int'(wrData)) > 0) begin
        frArmed = 1;
        frStart = cyc + 2;
        frNeed = framesAfter(int'(wrAddr), int'(wrData));
        frSeen = 0;
      end
      nLog++;
      waitCnt = 0;
    end
    if (rstN && panelRst != rstLast && nRstEdge < 8) begin
      rstEdge[nRstEdge] = cyc;
      nRstEdge++;
    end
    rstLast = panelRst;
    if (rstN && pwrEn && !pwrLast) pwrRise = cyc;
    if (rstN && !pwrEn && pwrLast) pwrFalls++;
    pwrLast = pwrEn;
    if (rstN && displayOn && !onLast) onRise = cyc;
    if (rstN && !displayOn && onLast) onFall = cyc;
    onLast = displayOn;
  end

  task automatic checkList(input int base, input int n, input bit isSleep, input int skip, input string req);
    for (int i = 0; i < n; i++) begin
      logic [23:0] e;
      e = isSleep ? expSleep(i) : expWake(i + skip);
      chk(logA[base+i] == int'(e[23:16]) && logD[base+i] == int'(e[15:0]), req,
          (logA[base+i] << 16) | logD[base+i], int'(e));
    end
  endtask

  task automatic checkFrames(input int lo, input int hi, input int expCnt);
    int seen = 0;
    for (int k = lo; k <= hi; k++) begin
      if (framesAfter(logA[k-1], logD[k-1]) > 0) begin
        seen++;
        chk(logReq[k] == logFrExp[k], "R7 frame wait", logReq[k], logFrExp[k]);
      end
    end
    chk(seen == expCnt, "R7 frame wait count", seen, expCnt);
  endtask

  task automatic testReset;
    @(negedge clk);
    chk({wrReq, panelRst, pwrEn, displayOn} == 4'b0, "R1 reset outputs",
        int'({wrReq, panelRst, pwrEn, displayOn}), 0);
  endtask

  task automatic testBoot;
    while (!(nLog >= 13 && onRise >= 0)) @(negedge clk);
    chk(nRstEdge == 3, "R2 reset line edges", nRstEdge, 3);
    chk(rstEdge[1] - rstEdge[0] == MSW, "R2 first high hold", rstEdge[1] - rstEdge[0], MSW);
    chk(rstEdge[2] - rstEdge[1] == MSW, "R2 low hold", rstEdge[2] - rstEdge[1], MSW);
    chk(pwrRise - rstEdge[2] == MSW, "R3 power after reset", pwrRise - rstEdge[2], MSW);
    chk(logReq[0] - pwrRise == MSW, "R3 first write after power", logReq[0] - pwrRise, MSW);
    checkList(0, 13, 1'b0, 1, "R4 boot write");
    chk(logReq[1] - logAck[0] == MSW, "R6 ms wait", logReq[1] - logAck[0], MSW);
    checkFrames(1, 12, 3);
    chk(onRise - logAck[12] == 2, "R8 on after boot", onRise - logAck[12], 2);
  endtask

  task automatic testStandbyIn;
    while (!(nLog >= 19 && onFall >= 0)) @(negedge clk);
    chk(logReq[13] == onRise + 1, "R12 deferred standby", logReq[13], onRise + 1);
    checkList(13, 6, 1'b1, 0, "R9 standby write");
    checkFrames(14, 18, 1);
    chk(onFall - logAck[18] == 2, "R8 off after standby", onFall - logAck[18], 2);
  endtask

  task automatic testNoop(input logic val);
    int base;
    panelEnable = val;
    base = nLog;
    repeat (300) @(negedge clk);
    chk(nLog == base, "R11 no writes on matching enable", nLog, base);
    chk(displayOn == val, "R11 display state holds", int'(displayOn), int'(val));
  endtask

  task automatic testWake;
    panelEnable = 1'b1;
    while (!(nLog >= 33 && displayOn)) @(negedge clk);
    @(negedge clk);
    checkList(19, 14, 1'b0, 0, "R10 wake write");
    chk(logReq[21] - logAck[20] == MSW, "R6 ms wait in wake", logReq[21] - logAck[20], MSW);
    checkFrames(20, 32, 3);
    chk(onRise - logAck[32] == 2, "R8 on after wake", onRise - logAck[32], 2);
    chk(nRstEdge == 3 && pwrFalls == 0 && pwrEn && panelRst, "R3 lines untouched by standby",
        nRstEdge + 16 * pwrFalls, 3);
  endtask

  initial begin
    panelEnable = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    testReset;
    rstN = 1'b1;
    testBoot;
    testStandbyIn;
    testNoop(1'b0);
    testWake;
    testNoop(1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4/R9/R10 progress actual=%0d expected=33", nLog);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule